// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers five interrupt request lines for a small processor core. One line cannot be masked. Three restart lines each have a fixed vector. The fifth is a general-purpose line whose service needs an acknowledge. The core pulses a boundary strobe between instructions. On that strobe the controller picks the most urgent eligible request. In the following cycle it reports which source won, the vector address, and a one-cycle take pulse. When the general-purpose line wins, it also raises an acknowledge pulse. Stacking the return address and fetching an opcode from the requesting device remain the core's job.

The core controls the global enable through two strobes, one that sets it and one that clears it. The controller clears the enable by itself whenever it accepts an interrupt. The current enable state is visible on an output.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `take_o`, `inta_o` and `ie_o` are 0, and `src_o` and `vec_o` are 0.
- R2: An interrupt is accepted only in a cycle where `boundary_i` is high, and at most one per strobe. `take_o` is high for exactly the one cycle after that edge. `src_o` and `vec_o` are loaded in the same cycle and hold until the next accept. A strobe with no eligible request changes nothing.
- R3: The nonmaskable line (`trap_i`, source code 0, vector 0x0024) wins over every other line. It ignores both `ie_o` and `mask_i`.
- R4: `trap_i` becomes eligible only when a clock edge sees it high after an edge that saw it low, and it then stays high. If it is accepted while still high, it does not fire again until it has gone low and risen again. If it drops before a strobe, the request is lost. If the strobe falls in the same cycle as the first high sample, that strobe does not accept it.
- R5: Among the maskable lines the ranking is, from highest to lowest: `rst75_i` (code 1, vector 0x003C), `rst65_i` (code 2, vector 0x0034), `rst55_i` (code 3, vector 0x002C), `intr_i` (code 4, vector 0x0000).
- R6: When `mask_i[2]` is 1, `rst75_i` is blocked. When `mask_i[1]` is 1, `rst65_i` is blocked. When `mask_i[0]` is 1, `rst55_i` is blocked. `intr_i` has no mask bit.
- R7: `ie_o` is set by `en_set_i` and cleared by `en_clr_i`, one cycle after the strobe. While `ie_o` is 0, no maskable line is accepted.
- R8: Every accept, including the nonmaskable one, clears `ie_o`. This takes precedence over an `en_set_i` given in the same cycle.
- R9: A rising edge on `rst75_i` is latched whether or not the line is masked. The latch stays pending after the input falls and is cleared only when that source is accepted.
- R10: `rst65_i`, `rst55_i` and `intr_i` are sampled as levels at the strobe and are not remembered. When `intr_i` is accepted, `inta_o` goes high in the same cycle as `take_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Nonmaskable request |
| rst75_i | input | 1 | Edge-latched restart request |
| rst65_i | input | 1 | Level restart request |
| rst55_i | input | 1 | Level restart request |
| intr_i | input | 1 | General-purpose level request |
| mask_i | input | 3 | Restart masks: [2] for rst75, [1] for rst65, [0] for rst55 |
| en_set_i | input | 1 | Set the global enable |
| en_clr_i | input | 1 | Clear the global enable |
| boundary_i | input | 1 | Instruction boundary strobe |
| take_o | output | 1 | One-cycle accept pulse |
| src_o | output | 3 | Code of the accepted source |
| vec_o | output | 16 | Vector address of the accepted source |
| inta_o | output | 1 | General-purpose acknowledge pulse |
| ie_o | output | 1 | Global enable state |

## Verification
The core of the bench is a sweep over all 256 combinations of the three masks, the latched top restart line, the two level restart lines, the general-purpose line and the enable. Each combination starts from a fresh reset, so the result depends only on ranking, masking and gating. A separate directed sequence on the nonmaskable line separates four cases: a held level, a fresh rising edge, a pulse that is dropped early, and an edge that arrives in the same cycle as the strobe. Further cases separate the edge latch from plain level requests, and an accept from an `en_set_i` given in the same cycle.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trap_i,
  input  logic        rst75_i,
  input  logic        rst65_i,
  input  logic        rst55_i,
  input  logic        intr_i,
  input  logic [2:0]  mask_i,
  input  logic        en_set_i,
  input  logic        en_clr_i,
  input  logic        boundary_i,
  output logic        take_o,
  output logic [2:0]  src_o,
  output logic [15:0] vec_o,
  output logic        inta_o,
  output logic        ie_o
);
  localparam logic [2:0] SRC_TRAP = 3'd0;
  localparam logic [2:0] SRC_R75  = 3'd1;
  localparam logic [2:0] SRC_R65  = 3'd2;
  localparam logic [2:0] SRC_R55  = 3'd3;
  localparam logic [2:0] SRC_GP   = 3'd4;

  logic trap_q, trap_arm, r75_q, r75_lat;
  logic [2:0]  win;
  logic [15:0] wvec;

  wire trap_ok = trap_arm & trap_i;
  wire ok75    = ie_o & ~mask_i[2] & r75_lat;
  wire ok65    = ie_o & ~mask_i[1] & rst65_i;
  wire ok55    = ie_o & ~mask_i[0] & rst55_i;
  wire okgp    = ie_o & intr_i;
  wire accept  = boundary_i & (trap_ok | ok75 | ok65 | ok55 | okgp);

  always_comb begin
    if (trap_ok)   begin win = SRC_TRAP; wvec = 16'h0024; end
    else if (ok75) begin win = SRC_R75;  wvec = 16'h003C; end
    else if (ok65) begin win = SRC_R65;  wvec = 16'h0034; end
    else if (ok55) begin win = SRC_R55;  wvec = 16'h002C; end
    else           begin win = SRC_GP;   wvec = 16'h0000; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q   <= 1'b0;
      trap_arm <= 1'b0;
      r75_q    <= 1'b0;
      r75_lat  <= 1'b0;
      take_o   <= 1'b0;
      inta_o   <= 1'b0;
      src_o    <= 3'd0;
      vec_o    <= 16'h0000;
      ie_o     <= 1'b0;
    end else begin
      trap_q <= trap_i;
      r75_q  <= rst75_i;
      if (accept && win == SRC_TRAP) trap_arm <= 1'b0;
      else if (trap_i && !trap_q)    trap_arm <= 1'b1;
      else if (!trap_i)              trap_arm <= 1'b0;
      r75_lat <= (r75_lat & ~(accept && win == SRC_R75)) | (rst75_i & ~r75_q);
      take_o <= accept;
      inta_o <= accept && win == SRC_GP;
      if (accept) begin
        src_o <= win;
        vec_o <= wvec;
      end
      if (accept)        ie_o <= 1'b0;
      else if (en_set_i) ie_o <= 1'b1;
      else if (en_clr_i) ie_o <= 1'b0;
    end
  end
endmodule

module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  mask_i,
  input logic        boundary_i,
  input logic        take_o,
  input logic [2:0]  src_o,
  input logic [15:0] vec_o,
  input logic        inta_o,
  input logic        ie_o
);
  assert_take_after_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));
  assert_take_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  assert_trap_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == 3'd0) |-> vec_o == 16'h0024);
  assert_mask_blocks_r75_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == 3'd1) |-> $past(!mask_i[2]));
  assert_maskable_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o != 3'd0) |-> $past(ie_o));
  assert_accept_clears_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ie_o);
  assert_ack_only_general_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |-> (take_o && src_o == 3'd4));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mask_i(mask_i), .boundary_i(boundary_i),
  .take_o(take_o), .src_o(src_o), .vec_o(vec_o), .inta_o(inta_o), .ie_o(ie_o)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, intr_i = 0;
  logic [2:0] mask_i = 3'd0;
  logic en_set_i = 0, en_clr_i = 0, boundary_i = 0;
  logic take_o, inta_o, ie_o;
  logic [2:0] src_o;
  logic [15:0] vec_o;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rst75_i(rst75_i), .rst65_i(rst65_i),
    .rst55_i(rst55_i), .intr_i(intr_i), .mask_i(mask_i), .en_set_i(en_set_i),
    .en_clr_i(en_clr_i), .boundary_i(boundary_i), .take_o(take_o), .src_o(src_o),
    .vec_o(vec_o), .inta_o(inta_o), .ie_o(ie_o)
  );

  function automatic logic [15:0] vec_of(input logic [2:0] s);
    case (s)
      3'd0: return 16'h0024;
      3'd1: return 16'h003C;
      3'd2: return 16'h0034;
      3'd3: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_take(input string tag, input logic [2:0] s, input logic ia);
    check(tag, {take_o, src_o, vec_o, inta_o, ie_o}, {1'b1, s, vec_of(s), ia, 1'b0});
  endtask

  task automatic expect_none(input string tag, input logic ie);
    check(tag, {take_o, inta_o, ie_o}, {1'b0, 1'b0, ie});
  endtask

  task automatic do_reset();
    rst_n = 0; trap_i = 0; rst75_i = 0; rst65_i = 0; rst55_i = 0; intr_i = 0;
    mask_i = 0; en_set_i = 0; en_clr_i = 0; boundary_i = 0;
    step(); step(); rst_n = 1; step();
  endtask

  task automatic strobe();
    boundary_i = 1; step(); boundary_i = 0;
  endtask

  task automatic enable();
    en_set_i = 1; step(); en_set_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R1", {take_o, src_o, vec_o, inta_o, ie_o}, 32'd0);

    for (int c = 0; c < 256; c++) begin
      logic [2:0] m, s;
      logic b75, b65, b55, bgp, ie, t;
      string tag;
      m = c[2:0]; b75 = c[3]; b65 = c[4]; b55 = c[5]; bgp = c[6]; ie = c[7];
      t = 1'b1; s = 3'd0;
      if (!ie) t = 1'b0;
      else if (b75 && !m[2]) s = 3'd1;
      else if (b65 && !m[1]) s = 3'd2;
      else if (b55 && !m[0]) s = 3'd3;
      else if (bgp) s = 3'd4;
      else t = 1'b0;
      tag = !ie ? "R7" : (m != 0 ? "R6" : "R5");
      do_reset();
      mask_i = m; rst65_i = b65; rst55_i = b55; intr_i = bgp; rst75_i = b75;
      step(); rst75_i = 0;
      if (ie) enable(); else step();
      strobe();
      if (t) expect_take(tag, s, s == 3'd4);
      else begin
        check(tag, {take_o, src_o, vec_o, inta_o, ie_o}, {1'b0, 3'd0, 16'h0, 1'b0, ie});
      end
    end

    do_reset();
    en_set_i = 1; intr_i = 1; rst75_i = 1; trap_i = 1;
    step(); en_set_i = 0; rst75_i = 0;
    strobe();
    expect_take("R3", 3'd0, 1'b0);
    step();
    expect_none("R2", 1'b0);
    enable(); strobe();
    expect_take("R4", 3'd1, 1'b0);
    strobe();
    expect_none("R7", 1'b0);
    enable(); strobe();
    expect_take("R9", 3'd4, 1'b1);
    trap_i = 0; step(); trap_i = 1; step(); strobe();
    expect_take("R4", 3'd0, 1'b0);
    trap_i = 0; step(); trap_i = 1; step(); trap_i = 0; step(); strobe();
    expect_none("R4", 1'b0);
    trap_i = 1; boundary_i = 1; step(); boundary_i = 0;
    expect_none("R4", 1'b0);
    strobe();
    expect_take("R4", 3'd0, 1'b0);
    trap_i = 0;

    intr_i = 1; enable();
    boundary_i = 1; en_set_i = 1; step(); boundary_i = 0; en_set_i = 0;
    expect_take("R8", 3'd4, 1'b1);
    enable(); en_clr_i = 1; step(); en_clr_i = 0; strobe();
    expect_none("R7", 1'b0);
    intr_i = 0; enable(); strobe();
    expect_none("R2", 1'b1);
    intr_i = 1; step(); intr_i = 0; step(); strobe();
    expect_none("R10", 1'b1);
    mask_i = 3'b100; rst75_i = 1; step(); rst75_i = 0; step(); strobe();
    expect_none("R6", 1'b1);
    mask_i = 3'b000; strobe();
    expect_take("R9", 3'd1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule